// File: doc/BRIEF.md
# MDIO Station Management Slave

This block is the serial management target of a physical-layer device. It runs entirely on the management clock (MDC), samples MDIO on each rising edge, and walks through an incoming management frame: preamble, start pattern, opcode, PHY address, register address, turnaround and a 16-bit data field. When a frame addresses this device, it either fetches a register value and shifts it back onto the shared MDIO line, or collects 16 data bits and commits them to the register file.

The pad is split into an input (`mdio_i`), an output value (`mdio_o`) and an output enable (`mdio_oe`), so the tri-state buffer lives in the pad ring. Whenever the enable is low, `mdio_o` rests at 1, so a released line reads as ones. The register file attaches through a plain port: the block presents `reg_addr`, and the register file must answer combinationally with `reg_rdata` and `reg_exists`. A write arrives as a one-cycle `reg_we` strobe with `reg_wdata`. The register port has no valid/ready handshake and no back-pressure. The register file must take the strobe in the cycle it is given and must settle its read answer within one MDC period of a change on `reg_addr`. The device's own address comes from the `phy_addr` strap input, which is normally tied to 1.

Top module: `mdio_slave`

## Requirements
- R1: While reset is asserted and after it is released with no frame in progress, `mdio_oe` and `reg_we` are 0 and `mdio_o` is 1. Whenever `mdio_oe` is 0, `mdio_o` is 1.
- R2: A frame begins after a preamble of one or more 1 bits followed by the start pattern 0 then 1. Preambles of 1, 2 and 32 ones are all accepted. A 0 that is not followed by a 1 returns the parser to waiting for a preamble.
- R3: The two bits after the start pattern are the opcode: 10 is a read and 01 is a write. The codes 00 and 11 abandon the frame, so nothing is driven and no write strobe is given.
- R4: The next 5 bits are the PHY address (MSB first) and the 5 after that are the register address (MSB first). A frame is accepted when the PHY address equals `phy_addr` or is 00000 (broadcast). For any other PHY address the block never drives MDIO, so the bus reads all ones, and it never strobes a write.
- R5: For an accepted read, `mdio_oe` is high for exactly 17 bit periods: from the second turnaround bit through the last data bit. `mdio_o` is 0 in the second turnaround bit, and the 16 data bits follow MSB first.
- R6: An accepted read of a register for which `reg_exists` is 0 drives 16 ones in the data field.
- R7: For an accepted write, `reg_we` is high for exactly one MDC period, namely the period after the 16th data bit. During that period `reg_wdata` holds the data field (first received bit as bit 15) and `reg_addr` holds the register address. `reg_we` is never high at any other time, and never while `mdio_oe` is high.
- R8: An accepted write to a register for which `reg_exists` is 0 produces no `reg_we` strobe.
- R9: Frames may follow each other with no gap. The single preamble bit of the next frame may fall in the period where the previous write commits or the previous read releases the line, and the next frame is still decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | This device's PHY address strap |
| mdio_i | input | 1 | Sampled value of the MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO when enabled; 1 otherwise |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| reg_addr | output | 5 | Register address of the current frame |
| reg_wdata | output | 16 | Data of the last committed write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Read data for `reg_addr` |
| reg_exists | input | 1 | High when `reg_addr` names an implemented register |

## Verification
Two functions can fall in the same cycle: the end of one frame and the start of the next. The write commit strobe, or the release of the line after a read, lands in the same MDC period as the one-bit preamble of a following frame. The bench provokes this by sending almost every frame back to back with a one-bit preamble. In that shared period it checks the strobe, the write data, the address and that the line has been released. It then checks that the next frame's read data or commit comes out bit-exact against a register model kept in the bench.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_ST,
    S_HDR,
    S_TA,
    S_DATA
  } mdio_st_e;

  localparam int OP_W = 2;
  localparam logic [OP_W-1:0] OP_RD = 2'b10;
  localparam logic [OP_W-1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mdio_frame_parse.sv
module mdio_frame_parse
  import mdio_slv_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_i,
  input  logic [ADDR_W-1:0] phy_addr,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              ta1_end,
  output logic              ta2_end,
  output logic              data_bit,
  output logic              data_last
);
  localparam int HDR_W   = OP_W + 2 * ADDR_W;
  localparam int CNT_MAX = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX);

  mdio_st_e          st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-2:0]  hdr_q;
  logic [HDR_W-1:0]  hdr_full;
  logic [OP_W-1:0]   op_f;
  logic [ADDR_W-1:0] phy_f;
  logic [ADDR_W-1:0] reg_f;
  logic              hdr_end;
  logic              op_ok;
  logic              addr_ok;
  logic              rd_hit_q;
  logic              wr_hit_q;
  logic [ADDR_W-1:0] reg_addr_q;

  // Header bits arrive MSB first: opcode, PHY address, register address.
  assign hdr_full = {hdr_q, mdio_i};
  assign op_f     = hdr_full[HDR_W-1 -: OP_W];
  assign phy_f    = hdr_full[2*ADDR_W-1 -: ADDR_W];
  assign reg_f    = hdr_full[ADDR_W-1:0];
  assign hdr_end  = (st_q == S_HDR) && (cnt_q == CNT_W'(HDR_W - 1));
  assign op_ok    = (op_f == OP_RD) || (op_f == OP_WR);
  assign addr_ok  = (phy_f == phy_addr) || (phy_f == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      cnt_q      <= '0;
      hdr_q      <= '0;
      rd_hit_q   <= 1'b0;
      wr_hit_q   <= 1'b0;
      reg_addr_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (mdio_i) st_q <= S_PRE;
        S_PRE:  if (!mdio_i) st_q <= S_ST;
        S_ST: begin
          cnt_q <= '0;
          st_q  <= mdio_i ? S_HDR : S_IDLE;
        end
        S_HDR: begin
          hdr_q <= hdr_full[HDR_W-2:0];
          cnt_q <= cnt_q + 1'b1;
          if (hdr_end) begin
            cnt_q <= '0;
            if (op_ok) begin
              st_q       <= S_TA;
              rd_hit_q   <= (op_f == OP_RD) && addr_ok;
              wr_hit_q   <= (op_f == OP_WR) && addr_ok;
              reg_addr_q <= reg_f;
            end else begin
              st_q <= S_IDLE;
            end
          end
        end
        S_TA: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            cnt_q <= '0;
            st_q  <= S_DATA;
          end
        end
        S_DATA: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            cnt_q <= '0;
            st_q  <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rd_hit    = rd_hit_q;
  assign wr_hit    = wr_hit_q;
  assign reg_addr  = reg_addr_q;
  assign ta1_end   = (st_q == S_TA) && (cnt_q == '0);
  assign ta2_end   = (st_q == S_TA) && (cnt_q == CNT_W'(1));
  assign data_bit  = (st_q == S_DATA);
  assign data_last = data_bit && (cnt_q == CNT_W'(DATA_W - 1));
endmodule

// File: rtl/mdio_rd_drive.sv
module mdio_rd_drive #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hit,
  input  logic              ta1_end,
  input  logic              ta2_end,
  input  logic              data_bit,
  input  logic              data_last,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_exists,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic [DATA_W-1:0] sr_q;
  logic              oe_q;
  logic              o_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      oe_q <= 1'b0;
      o_q  <= 1'b1;
    end else if (ta1_end && rd_hit) begin
      // Take the line for the second turnaround bit, driving 0.
      oe_q <= 1'b1;
      o_q  <= 1'b0;
      sr_q <= reg_exists ? reg_rdata : '1;
    end else if (oe_q) begin
      if (data_last) begin
        oe_q <= 1'b0;
        o_q  <= 1'b1;
      end else if (ta2_end || data_bit) begin
        o_q  <= sr_q[DATA_W-1];
        sr_q <= {sr_q[DATA_W-2:0], 1'b1};
      end
    end
  end

  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
endmodule

// File: rtl/mdio_wr_commit.sv
module mdio_wr_commit #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_i,
  input  logic              wr_hit,
  input  logic              data_bit,
  input  logic              data_last,
  input  logic              reg_exists,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata
);
  logic [DATA_W-2:0] sr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (data_bit) sr_q <= {sr_q[DATA_W-3:0], mdio_i};
      if (data_last && wr_hit && reg_exists) begin
        we_q    <= 1'b1;
        wdata_q <= {sr_q, mdio_i};
      end
    end
  end

  assign reg_we    = we_q;
  assign reg_wdata = wdata_q;
endmodule

// File: rtl/mdio_slave.sv
module mdio_slave #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_exists
);
  logic rd_hit;
  logic wr_hit;
  logic ta1_end;
  logic ta2_end;
  logic data_bit;
  logic data_last;

  mdio_frame_parse #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parse (
    .clk       (mdc),
    .rst_n     (rst_n),
    .mdio_i    (mdio_i),
    .phy_addr  (phy_addr),
    .rd_hit    (rd_hit),
    .wr_hit    (wr_hit),
    .reg_addr  (reg_addr),
    .ta1_end   (ta1_end),
    .ta2_end   (ta2_end),
    .data_bit  (data_bit),
    .data_last (data_last)
  );

  mdio_rd_drive #(.DATA_W(DATA_W)) u_rd (
    .clk        (mdc),
    .rst_n      (rst_n),
    .rd_hit     (rd_hit),
    .ta1_end    (ta1_end),
    .ta2_end    (ta2_end),
    .data_bit   (data_bit),
    .data_last  (data_last),
    .reg_rdata  (reg_rdata),
    .reg_exists (reg_exists),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );

  mdio_wr_commit #(.DATA_W(DATA_W)) u_wr (
    .clk        (mdc),
    .rst_n      (rst_n),
    .mdio_i     (mdio_i),
    .wr_hit     (wr_hit),
    .data_bit   (data_bit),
    .data_last  (data_last),
    .reg_exists (reg_exists),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata)
  );
endmodule

// File: rtl/mdio_slave_chk.sv
module mdio_slave_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input logic              mdc,
  input logic              rst_n,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              reg_we,
  input logic              reg_exists,
  input logic [ADDR_W-1:0] reg_addr
);
  localparam int RUN_MAX = DATA_W + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic [RUN_W-1:0] oe_run;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) oe_run <= '0;
    else        oe_run <= mdio_oe ? oe_run + 1'b1 : '0;
  end

  // R1
  idle_high_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    !mdio_oe |-> mdio_o);

  // R5
  ta_zero_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  // R5
  drive_len_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(mdio_oe) |-> (oe_run == RUN_W'(RUN_MAX)));

  // R5
  drive_max_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> (oe_run < RUN_W'(RUN_MAX)));

  // R7
  commit_pulse_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R7
  commit_addr_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_we |-> $stable(reg_addr));

  // R7
  commit_quiet_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_we |-> !mdio_oe);

  // R8
  commit_exist_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_we |-> reg_exists);
endmodule

bind mdio_slave mdio_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .mdc        (mdc),
  .rst_n      (rst_n),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .reg_we     (reg_we),
  .reg_exists (reg_exists),
  .reg_addr   (reg_addr)
);

// File: tb/tb_mdio_slave.sv
`timescale 1ns/1ps
module tb_mdio_slave;
  logic        mdc = 1'b0;
  logic        rst_n;
  logic [4:0]  phy_addr;
  logic        mdio_i;
  logic        mdio_o;
  logic        mdio_oe;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        reg_we;
  logic [15:0] reg_rdata;
  logic        reg_exists;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] mem [0:31];
  logic [15:0] shadow [0:31];

  always #2.5 mdc = ~mdc;

  mdio_slave dut (
    .mdc(mdc), .rst_n(rst_n), .phy_addr(phy_addr), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .reg_exists(reg_exists)
  );

  // Register file model: addresses 0..23 exist.
  assign reg_exists = (reg_addr < 5'd24);
  assign reg_rdata  = mem[reg_addr];
  always @(posedge mdc) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic bus();
    return mdio_oe ? mdio_o : 1'b1;
  endfunction

  task automatic idle_bits(input int n, input logic b);
    for (int k = 0; k < n; k++) begin
      chk(!mdio_oe, "R1", "oe idle", 16'(mdio_oe), 16'h0);
      mdio_i = b;
      @(negedge mdc);
    end
  endtask

  // Called and returning at a negedge. Periods j = 0..31 follow the preamble;
  // the period after the last data bit is checked before returning.
  task automatic frame(input int pre_len, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] rga,
                       input logic [15:0] wd, input string tag);
    bit rd, wr, hit, ex, exp_oe, exp_we;
    logic [15:0] exp_rd;
    logic b;
    int j;
    rd  = (op == 2'b10);
    wr  = (op == 2'b01);
    hit = (phy == phy_addr) || (phy == 5'd0);
    ex  = (rga < 5'd24);
    exp_rd = ex ? shadow[rga] : 16'hFFFF;
    for (int p = 0; p < pre_len + 32; p++) begin
      j = p - pre_len;
      exp_oe = rd && hit && (j >= 15) && (j <= 31);
      chk(mdio_oe == exp_oe, tag, "oe", 16'(mdio_oe), 16'(exp_oe));
      if (p != 0) chk(!reg_we, tag, "early we", 16'(reg_we), 16'h0);
      if (j == 15)
        chk(bus() == !(rd && hit), tag, "ta2", 16'(bus()), 16'(!(rd && hit)));
      if (j >= 16) begin
        b = (rd && hit) ? exp_rd[31-j] : 1'b1;
        chk(bus() == b, tag, "rdbit", 16'(bus()), 16'(b));
      end
      if (j < 0) b = 1'b1;
      else if (j == 0) b = 1'b0;
      else if (j == 1) b = 1'b1;
      else if (j <= 3) b = op[3-j];
      else if (j <= 8) b = phy[8-j];
      else if (j <= 13) b = rga[13-j];
      else if (j <= 15) b = wr ? (j == 14) : 1'b1;
      else b = wr ? wd[31-j] : 1'b1;
      mdio_i = b;
      @(negedge mdc);
    end
    exp_we = wr && hit && ex;
    chk(reg_we == exp_we, tag, "commit", 16'(reg_we), 16'(exp_we));
    chk(!mdio_oe, tag, "released", 16'(mdio_oe), 16'h0);
    if (exp_we) begin
      chk(reg_wdata == wd, tag, "wdata", reg_wdata, wd);
      chk(reg_addr == rga, tag, "waddr", 16'(reg_addr), 16'(rga));
      shadow[rga] = wd;
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      mem[i] = 16'((i * 16'h0123) ^ 16'hA500);
      shadow[i] = mem[i];
    end
    rst_n = 1'b0; mdio_i = 1'b1; phy_addr = 5'd1;
    repeat (3) @(negedge mdc);
    // R1 reset state
    chk(!mdio_oe && mdio_o && !reg_we, "R1", "reset outs",
        {13'd0, mdio_oe, mdio_o, reg_we}, 16'h0002);
    rst_n = 1'b1;
    idle_bits(2, 1'b0);
    chk(!mdio_oe && mdio_o && !reg_we, "R1", "post reset",
        {13'd0, mdio_oe, mdio_o, reg_we}, 16'h0002);

    // R2 preamble lengths, reads of a known register
    frame(1, 2'b10, 5'd1, 5'd2, 16'h0, "R2");
    frame(2, 2'b10, 5'd1, 5'd3, 16'h0, "R2");
    frame(32, 2'b10, 5'd1, 5'd4, 16'h0, "R2");
    // R2 stray zeros then a frame
    idle_bits(3, 1'b0);
    frame(1, 2'b10, 5'd1, 5'd5, 16'h0, "R2");

    // R7 R8 R9 sweep: write every register back to back, then read back (R5 R6)
    for (int a = 0; a < 32; a++)
      frame(1, 2'b01, 5'd1, 5'(a), 16'((a * 16'h9E37) ^ 16'h5AC3),
            (a < 24) ? "R7" : "R8");
    for (int a = 0; a < 32; a++)
      frame(1, 2'b10, 5'd1, 5'(a), 16'h0, (a < 24) ? "R5" : "R6");

    // R4 PHY address sweep with strap 1, then strap 5
    for (int s = 0; s < 2; s++) begin
      idle_bits(1, 1'b0);
      phy_addr = (s == 0) ? 5'd1 : 5'd5;
      for (int ph = 0; ph < 32; ph++) begin
        frame(1, 2'b01, 5'(ph), 5'd7, 16'(16'h3000 + ph * 16'h0111 + s), "R4");
        frame(1, 2'b10, 5'(ph), 5'd7, 16'h0, "R4");
      end
    end

    // R3 invalid opcodes: no drive, no commit, register unchanged
    frame(1, 2'b00, 5'd5, 5'd8, 16'hFFFF, "R3");
    frame(1, 2'b11, 5'd5, 5'd8, 16'hFFFF, "R3");
    frame(1, 2'b10, 5'd5, 5'd8, 16'h0, "R3");

    // R9 alternating write/read with one-bit preambles
    for (int a = 0; a < 24; a++) begin
      frame(1, 2'b01, 5'd0, 5'(a), 16'(~(a * 16'h0F0F)), "R9");
      frame(1, 2'b10, 5'd5, 5'(a), 16'h0, "R9");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge mdc);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule